// File: doc/BRIEF.md
# Multi-Lane Warp Element Sequencer

This block runs one element-wise warp operation, C[t] = A[t] + B[t], for every thread t of a fixed-size warp. The warp is executed on a small number of parallel lanes. Each lane owns private register banks for A, B and C. Thread t is stored in lane (t mod LANES), at row (t div LANES). Each cycle, one group of LANES consecutive threads is issued, one thread per lane, so a full warp is issued over THREADS/LANES cycles.

A start pulse supplies the block index, the block size and the element count. A thread takes part only if its global element index, block index times block size plus thread index, is below the element count. Threads outside that range leave their C entry untouched. Before a run, a host fills A and B through a bank write port. After the one-cycle done pulse, the host reads C back through a bank read port.

Top module: `warp_lane_seq`

## Requirements
- R1: After reset, busy and done are both low.
- R2: A write with wr_en high and the block idle stores wr_data in the bank chosen by wr_sel, at thread wr_tid. Bank codes are 0 = A, 1 = B and 2 = C. The entry lands in lane wr_tid mod LANES, row wr_tid div LANES. rd_data returns, in the same cycle, the entry chosen by rd_sel and rd_tid.
- R3: When a run completes, every active thread t holds C[t] = (A[t] + B[t]) mod 2^DW.
- R4: Thread t is active exactly when blk_idx*blk_dim + t < n_elems. The product is taken at full width with no truncation.
- R5: An inactive thread's C entry keeps the value it held before the run.
- R6: A start seen while idle makes busy high in the next cycle. Issue takes THREADS/LANES cycles, and each lane adds with a two-cycle latency. done is a single-cycle pulse, high in the cycle THREADS/LANES+1 clock edges after the start edge, and busy is low in that cycle.
- R7: A start pulse that arrives while busy is high is ignored. It changes neither the run's timing nor its mask.
- R8: Bank writes presented while busy is high are ignored.
- R9: Bank code 3 selects no bank. Writes with code 3 change nothing, and reads with code 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, taken only while idle |
| blk_idx | input | IW | Block index of this warp |
| blk_dim | input | IW | Threads per block |
| n_elems | input | IW | Element count bounding active threads |
| wr_en | input | 1 | Bank write strobe |
| wr_sel | input | 2 | Bank select for writes (0 A, 1 B, 2 C, 3 none) |
| wr_tid | input | log2(THREADS) | Thread index for writes |
| wr_data | input | DW | Write data |
| rd_sel | input | 2 | Bank select for reads |
| rd_tid | input | log2(THREADS) | Thread index for reads |
| rd_data | output | DW | Combinational read data |
| busy | output | 1 | Run in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- Reset is applied before the first start.
- start is sampled only on clock edges, so a request held for several cycles counts once and later cycles fall inside the run.
- blk_idx, blk_dim and n_elems matter only on the accepted edge.

Stimulus drives every input on the falling edge and holds it for one whole cycle. It issues starts only as single-cycle pulses, and the one extra start arrives deliberately mid-run. Bank writes are mostly made while idle; the one exception is a deliberate write attempt in the middle of a run.

// File: rtl/warp_lane_seq.sv
module warp_lane_seq #(
  parameter int THREADS = 32,
  parameter int LANES   = 4,
  parameter int DW      = 16,
  parameter int IW      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [IW-1:0]                blk_idx,
  input  logic [IW-1:0]                blk_dim,
  input  logic [IW-1:0]                n_elems,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_sel,
  input  logic [$clog2(THREADS)-1:0]   wr_tid,
  input  logic [DW-1:0]                wr_data,
  input  logic [1:0]                   rd_sel,
  input  logic [$clog2(THREADS)-1:0]   rd_tid,
  output logic [DW-1:0]                rd_data,
  output logic                         busy,
  output logic                         done
);
  localparam int ROWS = THREADS / LANES;
  localparam int TW   = $clog2(THREADS);
  localparam int LW   = $clog2(LANES);
  localparam int RW   = $clog2(ROWS);
  localparam int GW   = 2 * IW + 1;
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic          busy_q, done_q, iss_q, s1_v_q;
  logic [RW-1:0] grp_q, s1_row_q;
  logic [GW-1:0] base_q;
  logic [IW-1:0] n_q;
  logic [DW-1:0] lane_rd [LANES];

  wire host_wr = wr_en && !busy_q;
  wire [LW-1:0] wr_lane = wr_tid[LW-1:0];
  wire [RW-1:0] wr_row  = wr_tid[TW-1:LW];
  wire [LW-1:0] rd_lane = rd_tid[LW-1:0];
  wire [RW-1:0] rd_row  = rd_tid[TW-1:LW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      iss_q    <= 1'b0;
      s1_v_q   <= 1'b0;
      grp_q    <= '0;
      s1_row_q <= '0;
      base_q   <= '0;
      n_q      <= '0;
    end else begin
      done_q   <= 1'b0;
      s1_v_q   <= iss_q;
      s1_row_q <= grp_q;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        iss_q  <= 1'b1;
        grp_q  <= '0;
        base_q <= GW'(blk_idx) * GW'(blk_dim);
        n_q    <= n_elems;
      end else if (iss_q) begin
        grp_q <= grp_q + RW'(1);
        if (grp_q == LAST_ROW) iss_q <= 1'b0;
      end
      if (s1_v_q && s1_row_q == LAST_ROW) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DW-1:0] bank_a [ROWS];
    logic [DW-1:0] bank_b [ROWS];
    logic [DW-1:0] bank_c [ROWS];
    logic [DW-1:0] s1_a, s1_b;
    logic          s1_m;
    wire  [TW-1:0] tid_k = {grp_q, LW'(k)};
    wire           act_k = (base_q + GW'(tid_k)) < GW'(n_q);

    always_ff @(posedge clk) begin
      if (host_wr && wr_lane == LW'(k)) begin
        case (wr_sel)
          2'd0:    bank_a[wr_row] <= wr_data;
          2'd1:    bank_b[wr_row] <= wr_data;
          2'd2:    bank_c[wr_row] <= wr_data;
          default: ;
        endcase
      end
      if (iss_q) begin
        s1_a <= bank_a[grp_q];
        s1_b <= bank_b[grp_q];
        s1_m <= act_k;
      end
      if (s1_v_q && s1_m) bank_c[s1_row_q] <= s1_a + s1_b;
    end

    always_comb begin
      case (rd_sel)
        2'd0:    lane_rd[k] = bank_a[rd_row];
        2'd1:    lane_rd[k] = bank_b[rd_row];
        2'd2:    lane_rd[k] = bank_c[rd_row];
        default: lane_rd[k] = '0;
      endcase
    end
  end

  assign rd_data = lane_rd[rd_lane];
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/warp_lane_seq_chk.sv
module warp_lane_seq_chk #(
  parameter int THREADS = 32,
  parameter int LANES   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  localparam int ROWS = THREADS / LANES;
  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> (!busy && !done));

  // R6
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == ROWS + 1));
endmodule

bind warp_lane_seq warp_lane_seq_chk #(.THREADS(THREADS), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
);

// File: tb/warp_lane_seq_tb.sv
`timescale 1ns/1ps
module warp_lane_seq_tb;
  localparam int THREADS = 32;
  localparam int LANES   = 4;
  localparam int DW      = 16;
  localparam int IW      = 16;
  localparam int TW      = $clog2(THREADS);
  localparam int ROWS    = THREADS / LANES;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IW-1:0] blk_idx = '0, blk_dim = '0, n_elems = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [TW-1:0] wr_tid = '0, rd_tid = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic busy, done;

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_a [THREADS];
  logic [DW-1:0] ref_b [THREADS];

  always #10 clk = ~clk;

  warp_lane_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_idx(blk_idx), .blk_dim(blk_dim),
    .n_elems(n_elems), .wr_en(wr_en), .wr_sel(wr_sel), .wr_tid(wr_tid),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_tid(rd_tid), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] sel, input int tid, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_tid = TW'(tid); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bread(input logic [1:0] sel, input int tid, output logic [DW-1:0] d);
    rd_sel = sel; rd_tid = TW'(tid);
    #1 d = rd_data;
  endtask

  task automatic fill_c(input logic [DW-1:0] s);
    for (int t = 0; t < THREADS; t++) bwrite(2'd2, t, s);
  endtask

  // inj: 0 none, 1 restart mid-run, 2 bank write mid-run
  task automatic run(input int bi, input int bd, input int n, input int inj,
                     input logic [DW-1:0] sent);
    int c;
    logic [DW-1:0] d;
    longint g;
    fill_c(sent);
    @(negedge clk);
    start = 1'b1; blk_idx = IW'(bi); blk_dim = IW'(bd); n_elems = IW'(n);
    @(negedge clk);
    start = 1'b0; blk_idx = '0; blk_dim = '0; n_elems = '0;
    chk("R6 busy after start", busy, 1);
    c = 0;
    while (!done && c < 40) begin
      if (c == 3 && inj == 1) begin
        start = 1'b1; blk_idx = '0; blk_dim = IW'(32); n_elems = '0;
      end
      if (c == 3 && inj == 2) begin
        wr_en = 1'b1; wr_sel = 2'd0; wr_tid = TW'(5); wr_data = ~ref_a[5];
      end
      if (c == 4) begin
        start = 1'b0; wr_en = 1'b0;
      end
      @(negedge clk);
      c++;
    end
    chk(inj == 1 ? "R7 done timing with restart" : "R6 done timing", c, ROWS + 1);
    chk("R6 busy low with done", busy, 0);
    @(negedge clk);
    chk("R6 done is one pulse", done, 0);
    for (int t = 0; t < THREADS; t++) begin
      g = longint'(bi) * longint'(bd) + t;
      bread(2'd2, t, d);
      if (g < n) chk("R3 sum of active thread", d, DW'(ref_a[t] + ref_b[t]));
      else       chk("R4 R5 inactive thread keeps C", d, sent);
    end
    if (inj == 2) begin
      bread(2'd0, 5, d);
      chk("R8 write during busy ignored", d, ref_a[5]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 done at reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);

    for (int t = 0; t < THREADS; t++) begin
      ref_a[t] = DW'($urandom);
      ref_b[t] = DW'($urandom);
      if (t == 0) begin ref_a[t] = '1; ref_b[t] = DW'(3); end
      bwrite(2'd0, t, ref_a[t]);
      bwrite(2'd1, t, ref_b[t]);
    end
    for (int t = 0; t < THREADS; t++) begin
      bread(2'd0, t, d); chk("R2 A readback", d, ref_a[t]);
      bread(2'd1, t, d); chk("R2 B readback", d, ref_b[t]);
    end
    fill_c(DW'(16'h1234));
    for (int t = 0; t < THREADS; t++) begin
      bread(2'd2, t, d); chk("R2 C readback", d, 16'h1234);
    end

    run(0, 32, 32, 0, DW'(16'hC001));
    run(0, 32, 20, 0, DW'(16'hC002));
    run(1, 32, 45, 0, DW'(16'hC003));
    run(3, 32, 100, 0, DW'(16'hC004));
    run(2, 32, 10, 0, DW'(16'hC005));
    run(0, 32, 0, 0, DW'(16'hC006));
    run(5, 7, 40, 0, DW'(16'hC007));
    run(1, 16, 40, 0, DW'(16'hC008));
    run(0, 32, 65535, 0, DW'(16'hC009));
    run(300, 300, 65535, 0, DW'(16'hC00A));
    run(0, 32, 17, 1, DW'(16'hC00B));
    run(0, 32, 32, 2, DW'(16'hC00C));

    // R9 bank code 3
    bwrite(2'd3, 0, DW'(16'h5A5A));
    bread(2'd3, 0, d); chk("R9 code 3 reads zero", d, 0);
    bread(2'd0, 0, d); chk("R9 A untouched by code 3", d, ref_a[0]);
    bread(2'd1, 0, d); chk("R9 B untouched by code 3", d, ref_b[0]);
    bread(2'd2, 0, d); chk("R9 C untouched by code 3", d, DW'(ref_a[0] + ref_b[0]));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule